// File: doc/BRIEF.md
# Block Address Translation Unit

This unit maps a 32-bit effective address onto a real page address through a small set of block-mapping entries. Each entry is a pair of 32-bit registers: an upper word that holds the effective block index, its length and its validity, and a lower word that holds the real block index and its protection. Instruction fetches use one array of entries and data accesses use a second, separate array. Software or a sequencer loads the entries through a single-word write port.

Each request carries an effective address, an access kind and a user/supervisor flag. One cycle later the unit answers with a hit flag, the real page address and read, write and execute grants. The block length is variable. It is given as a count of low index bits that the compare ignores. An entry is only live for the privilege levels whose valid bits are set. A static input selects an alternate legacy entry layout. In that layout the valid bit and the length come from the lower word, and the grants come from a key/protection table.

Top module: `bat_xlate`

## Requirements
- R1: A request with req_kind 2 (fetch) searches only the instruction array (cfg_iside=1 writes). Kinds 0 (read), 1 (write) and 3 search only the data array (cfg_iside=0 writes).
- R2: In normal mode an entry takes part in matching only if upper bit 1 is set and req_user=0, or upper bit 0 is set and req_user=1.
- R3: In normal mode the compare mask is 0xFFFE0000 AND NOT((upper AND 0x1FFC) shifted left 15). An entry matches when (ea AND mask) equals (upper AND 0xFFFE0000). Upper index bits that fall under the length field therefore prevent any match.
- R4: On a hit, rsp_raddr is ((lower AND mask) OR (ea AND NOT mask)) with its low PAGE_BITS (12) bits cleared.
- R5: When several entries of the searched array match, the one with the lowest index supplies the result.
- R6: In normal mode, lower[1:0] sets the grants. 00 gives no access, 01 gives read and execute, and 1x gives read, write and execute. A hit with no grants still reports rsp_hit=1.
- R7: With legacy_en=1, an entry is valid when lower bit 6 is set, and the mask is 0xFFFE0000 AND NOT(lower[5:0] shifted left 17). The key is upper bit 3 for supervisor and upper bit 2 for user, and pp is upper[1:0]. For key 0, pp 0, 1 or 2 grants read and write, and pp 3 grants read only. For key 1, pp 0 grants nothing, pp 1 or 3 grants read only, and pp 2 grants read and write. Execute is granted exactly when read is.
- R8: rsp_valid is high in exactly the cycle after each cycle in which req_valid is high.
- R9: A miss returns rsp_hit=0, rsp_raddr=0 and all grants 0.
- R10: An entry write with cfg_we in cycle N affects requests from cycle N+1 onward. A request in cycle N sees the previous contents. cfg_hi=1 selects the upper word, and cfg_idx selects the entry.
- R11: Reset clears every entry, so every lookup misses, and it drops rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_en | input | 1 | Selects the legacy entry layout |
| cfg_we | input | 1 | Entry write strobe |
| cfg_iside | input | 1 | 1 writes the instruction array, 0 the data array |
| cfg_hi | input | 1 | 1 writes the upper word, 0 the lower word |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_wdata | input | 32 | Word to write |
| req_valid | input | 1 | Lookup request |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 other data access |
| req_user | input | 1 | 1 user mode, 0 supervisor |
| rsp_valid | output | 1 | Response strobe, one cycle after req_valid |
| rsp_hit | output | 1 | An entry matched |
| rsp_raddr | output | 32 | Real page address |
| rsp_rd | output | 1 | Read granted |
| rsp_wr | output | 1 | Write granted |
| rsp_ex | output | 1 | Execute granted |

## Verification
The same block is probed with the same address under each privilege level and access kind. This shows whether side selection and the privilege valid bits work. Addresses just inside and just outside blocks of two different lengths check the mask, and an entry whose index has bits under its length field must never match. Overlapping entries show whether the lowest index wins. The legacy layout is swept through both keys and several protection values. A write issued in the same cycle as a lookup shows that the write does not take effect until the next cycle.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int WORD_W = 32;
  localparam logic [WORD_W-1:0] INDEX_MASK = 32'hFFFE_0000;
  localparam logic [1:0] KIND_FETCH = 2'd2;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } perm_t;

  // Key/protection table of the legacy layout; execute follows read.
  function automatic perm_t legacy_perm(input logic key, input logic [1:0] pp);
    perm_t p;
    p = '0;
    if (!key) begin
      p.rd = 1'b1;
      p.wr = (pp != 2'd3);
    end else begin
      p.rd = (pp != 2'd0);
      p.wr = (pp == 2'd2);
    end
    p.ex = p.rd;
    return p;
  endfunction

  // Normal layout: 00 none, 01 read+execute, 1x all.
  function automatic perm_t normal_perm(input logic [1:0] pp);
    perm_t p;
    p.rd = (pp != 2'd0);
    p.ex = (pp != 2'd0);
    p.wr = pp[1];
    return p;
  endfunction
endpackage

// File: rtl/bat_entry_match.sv
module bat_entry_match
  import bat_pkg::*;
#(
  parameter int PAGE_BITS = 12
) (
  input  logic [WORD_W-1:0] upper,
  input  logic [WORD_W-1:0] lower,
  input  logic [WORD_W-1:0] ea,
  input  logic              user,
  input  logic              legacy,
  output logic              hit,
  output logic [WORD_W-1:0] raddr,
  output perm_t             perm
);
  localparam logic [WORD_W-1:0] PAGE_MASK = ~((WORD_W'(1) << PAGE_BITS) - WORD_W'(1));

  logic              live;
  logic [WORD_W-1:0] len_bits;
  logic [WORD_W-1:0] mask;

  always_comb begin
    if (legacy) begin
      live     = lower[6];
      len_bits = {9'd0, lower[5:0], 17'd0};
      perm     = legacy_perm(user ? upper[2] : upper[3], upper[1:0]);
    end else begin
      live     = user ? upper[0] : upper[1];
      len_bits = {4'd0, upper[12:2], 17'd0};
      perm     = normal_perm(lower[1:0]);
    end
    mask  = INDEX_MASK & ~len_bits;
    hit   = live && ((ea & mask) == (upper & INDEX_MASK));
    raddr = ((lower & mask) | (ea & ~mask)) & PAGE_MASK;
  end
endmodule

// File: rtl/bat_side.sv
module bat_side
  import bat_pkg::*;
#(
  parameter int ENTRIES   = 4,
  parameter int PAGE_BITS = 12,
  localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              we_hi,
  input  logic [IDX_W-1:0]  widx,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] ea,
  input  logic              user,
  input  logic              legacy,
  output logic              hit,
  output logic [WORD_W-1:0] raddr,
  output perm_t             perm
);
  logic [WORD_W-1:0] up_q  [ENTRIES];
  logic [WORD_W-1:0] lo_q  [ENTRIES];
  logic              ent_hit   [ENTRIES];
  logic [WORD_W-1:0] ent_raddr [ENTRIES];
  perm_t             ent_perm  [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        up_q[i] <= '0;
        lo_q[i] <= '0;
      end
    end else if (we) begin
      if (we_hi) up_q[widx] <= wdata;
      else       lo_q[widx] <= wdata;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    bat_entry_match #(.PAGE_BITS(PAGE_BITS)) u_match (
      .upper  (up_q[g]),
      .lower  (lo_q[g]),
      .ea     (ea),
      .user   (user),
      .legacy (legacy),
      .hit    (ent_hit[g]),
      .raddr  (ent_raddr[g]),
      .perm   (ent_perm[g])
    );
  end

  // Descending scan: the lowest matching index is assigned last and wins.
  always_comb begin
    hit   = 1'b0;
    raddr = '0;
    perm  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (ent_hit[i]) begin
        hit   = 1'b1;
        raddr = ent_raddr[i];
        perm  = ent_perm[i];
      end
    end
  end
endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
  import bat_pkg::*;
#(
  parameter int ENTRIES   = 4,
  parameter int PAGE_BITS = 12,
  localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              legacy_en,
  input  logic              cfg_we,
  input  logic              cfg_iside,
  input  logic              cfg_hi,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  input  logic [31:0]       req_ea,
  input  logic [1:0]        req_kind,
  input  logic              req_user,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [31:0]       rsp_raddr,
  output logic              rsp_rd,
  output logic              rsp_wr,
  output logic              rsp_ex
);
  logic              side_hit   [2];
  logic [WORD_W-1:0] side_raddr [2];
  perm_t             side_perm  [2];
  logic              sel;

  // Side 0 holds data entries, side 1 instruction entries.
  for (genvar s = 0; s < 2; s++) begin : g_side
    bat_side #(.ENTRIES(ENTRIES), .PAGE_BITS(PAGE_BITS)) u_side (
      .clk    (clk),
      .rst    (rst),
      .we     (cfg_we && (cfg_iside == s[0])),
      .we_hi  (cfg_hi),
      .widx   (cfg_idx),
      .wdata  (cfg_wdata),
      .ea     (req_ea),
      .user   (req_user),
      .legacy (legacy_en),
      .hit    (side_hit[s]),
      .raddr  (side_raddr[s]),
      .perm   (side_perm[s])
    );
  end

  assign sel = (req_kind == KIND_FETCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_raddr <= '0;
      rsp_rd    <= 1'b0;
      rsp_wr    <= 1'b0;
      rsp_ex    <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit   <= side_hit[sel];
        rsp_raddr <= side_raddr[sel];
        rsp_rd    <= side_perm[sel].rd;
        rsp_wr    <= side_perm[sel].wr;
        rsp_ex    <= side_perm[sel].ex;
      end
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R8
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R8
  AST_MISS_IS_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_raddr == '0 && !rsp_rd && !rsp_wr && !rsp_ex)); // R9
  AST_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_raddr[PAGE_BITS-1:0] == '0)); // R4
  AST_EXEC_WITH_READ: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_ex == rsp_rd)); // R6
  AST_WRITE_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_wr) |-> rsp_rd); // R7
  AST_RESET_IDLE: assert property (@(posedge clk)
    $fell(rst) |-> !rsp_valid); // R11
endmodule

// File: tb/sim_bat_xlate.sv
`timescale 1ns/1ps
module sim_bat_xlate;
  localparam int N = 4;

  typedef struct {
    logic        hit;
    logic [31:0] raddr;
    logic        rd, wr, ex;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic legacy_en = 1'b0;
  logic cfg_we = 1'b0, cfg_iside = 1'b0, cfg_hi = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic req_valid = 1'b0;
  logic [31:0] req_ea = '0;
  logic [1:0]  req_kind = '0;
  logic req_user = 1'b0;
  logic rsp_valid, rsp_hit, rsp_rd, rsp_wr, rsp_ex;
  logic [31:0] rsp_raddr;

  int checks = 0, fails = 0, nreq = 0, nrsp = 0;
  bit done = 0;
  exp_t q[$];
  logic [31:0] sh_up [2][N];
  logic [31:0] sh_lo [2][N];

  always #2.5 clk = ~clk;

  bat_xlate #(.ENTRIES(N), .PAGE_BITS(12)) u0 (
    .clk, .rst, .legacy_en, .cfg_we, .cfg_iside, .cfg_hi, .cfg_idx, .cfg_wdata,
    .req_valid, .req_ea, .req_kind, .req_user,
    .rsp_valid, .rsp_hit, .rsp_raddr, .rsp_rd, .rsp_wr, .rsp_ex
  );

  function automatic exp_t model(input logic [31:0] ea, input logic [1:0] kind,
                                 input logic user, input string tag);
    exp_t e;
    int s;
    e = '{hit: 1'b0, raddr: 32'd0, rd: 1'b0, wr: 1'b0, ex: 1'b0, tag: tag};
    s = (kind == 2'd2) ? 1 : 0;                                   // R1
    for (int i = 0; i < N; i++) begin
      logic [31:0] u, l, m;
      logic v, key;
      u = sh_up[s][i];
      l = sh_lo[s][i];
      if (legacy_en) begin                                        // R7
        v = l[6];
        m = 32'hFFFE0000 & ~({26'd0, l[5:0]} << 17);
      end else begin                                              // R2, R3
        v = user ? u[0] : u[1];
        m = 32'hFFFE0000 & ~((u & 32'h1FFC) << 15);
      end
      if (!e.hit && v && ((ea & m) == (u & 32'hFFFE0000))) begin  // R5
        e.hit = 1'b1;
        e.raddr = ((l & m) | (ea & ~m)) & 32'hFFFFF000;           // R4
        if (legacy_en) begin
          key = user ? u[2] : u[3];
          case ({key, u[1:0]})
            3'b000, 3'b001, 3'b010: begin e.rd = 1; e.wr = 1; end
            3'b011:                 begin e.rd = 1; e.wr = 0; end
            3'b100:                 begin e.rd = 0; e.wr = 0; end
            3'b101, 3'b111:         begin e.rd = 1; e.wr = 0; end
            default:                begin e.rd = 1; e.wr = 1; end
          endcase
          e.ex = e.rd;
        end else begin                                            // R6
          e.rd = (l[1:0] != 2'b00);
          e.ex = (l[1:0] != 2'b00);
          e.wr = l[1];
        end
      end
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic shadow_write(input logic iside, input int idx, input logic hi,
                              input logic [31:0] d);
    if (hi) sh_up[iside][idx] = d;
    else    sh_lo[iside][idx] = d;
  endtask

  task automatic cfg_write(input logic iside, input int idx, input logic hi,
                           input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_iside = iside; cfg_idx = idx[1:0]; cfg_hi = hi; cfg_wdata = d;
    shadow_write(iside, idx, hi, d);
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic lookup(input logic [31:0] ea, input logic [1:0] kind,
                        input logic user, input string tag);
    @(negedge clk);
    q.push_back(model(ea, kind, user, tag));
    req_valid = 1; req_ea = ea; req_kind = kind; req_user = user;
    nreq++;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  // Write and lookup in the same cycle: the lookup must see the old entry (R10).
  task automatic write_and_lookup(input logic iside, input int idx, input logic hi,
                                  input logic [31:0] d, input logic [31:0] ea,
                                  input logic [1:0] kind, input logic user);
    @(negedge clk);
    q.push_back(model(ea, kind, user, "R10"));
    req_valid = 1; req_ea = ea; req_kind = kind; req_user = user;
    cfg_we = 1; cfg_iside = iside; cfg_idx = idx[1:0]; cfg_hi = hi; cfg_wdata = d;
    shadow_write(iside, idx, hi, d);
    nreq++;
    @(posedge clk); #1;
    req_valid = 0; cfg_we = 0;
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      nrsp++;
      if (q.size() == 0) begin
        check(0, "R8", $sformatf("response without request, actual rsp_valid=1 expected 0"));
      end else begin
        exp_t e;
        e = q.pop_front();
        check(rsp_hit === e.hit && rsp_raddr === e.raddr && rsp_rd === e.rd &&
              rsp_wr === e.wr && rsp_ex === e.ex, e.tag,
              $sformatf("actual hit=%0b ra=%h rwx=%0b%0b%0b expected hit=%0b ra=%h rwx=%0b%0b%0b",
                        rsp_hit, rsp_raddr, rsp_rd, rsp_wr, rsp_ex,
                        e.hit, e.raddr, e.rd, e.wr, e.ex));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < N; i++) begin sh_up[s][i] = '0; sh_lo[s][i] = '0; end
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check(rsp_valid === 1'b0, "R11", $sformatf("rsp_valid actual %0b expected 0", rsp_valid));
    lookup(32'h0000_0000, 2'd0, 0, "R11");                 // cleared entries miss
    lookup(32'h1001_2345, 2'd2, 0, "R9");

    // Data entry 0: 128K block at 0x10000000, supervisor only, RWX.
    cfg_write(0, 0, 1, 32'h1000_0002);
    cfg_write(0, 0, 0, 32'h8000_0002);
    lookup(32'h1001_2345, 2'd0, 0, "R4");                  // 0x80012000 RWX
    lookup(32'h1001_2345, 2'd0, 1, "R2");                  // user: miss
    lookup(32'h1001_2345, 2'd2, 0, "R1");                  // fetch side empty
    lookup(32'h1002_0000, 2'd1, 0, "R3");                  // just outside
    lookup(32'h1001_FFFF, 2'd3, 0, "R1");                  // kind 3 is data

    // Data entry 1: 512K block, both levels, read+execute.
    cfg_write(0, 1, 1, 32'h2000_000F);
    cfg_write(0, 1, 0, 32'h4000_0001);
    lookup(32'h2007_F123, 2'd1, 1, "R6");                  // hit, no write grant
    lookup(32'h2008_0000, 2'd0, 1, "R3");                  // just outside

    // Instruction entry 2 over the same region as data entry 0.
    cfg_write(1, 2, 1, 32'h1000_0003);
    cfg_write(1, 2, 0, 32'h9000_0001);
    lookup(32'h1001_0000, 2'd2, 1, "R1");                  // 0x90010000
    lookup(32'h1001_0000, 2'd0, 0, "R1");                  // data: 0x80010000

    // Overlaps at higher indices lose.
    cfg_write(0, 2, 1, 32'h1000_0003);
    cfg_write(0, 2, 0, 32'h6000_0002);
    cfg_write(0, 3, 1, 32'h2000_0003);
    cfg_write(0, 3, 0, 32'h5000_0002);
    lookup(32'h1000_0010, 2'd0, 0, "R5");
    lookup(32'h2001_0000, 2'd0, 1, "R5");
    lookup(32'h1000_0010, 2'd0, 1, "R5");                  // entry0 user-invalid: entry2

    // No-grant entry still hits.
    cfg_write(0, 3, 1, 32'h3000_0002);
    cfg_write(0, 3, 0, 32'h7000_0000);
    lookup(32'h3000_1000, 2'd0, 0, "R6");

    // Index bit under length field: never matches.
    cfg_write(1, 3, 1, 32'h5002_000F);
    cfg_write(1, 3, 0, 32'h7000_0002);
    lookup(32'h5002_0000, 2'd2, 0, "R3");
    lookup(32'h5000_0000, 2'd2, 0, "R3");

    // No request: no response.
    repeat (2) @(negedge clk);
    check(rsp_valid === 1'b0, "R8", $sformatf("idle rsp_valid actual %0b expected 0", rsp_valid));

    // Same-cycle write sees old contents, next cycle sees new.
    write_and_lookup(0, 1, 1, 32'h0000_0000, 32'h2007_F123, 2'd0, 1);
    lookup(32'h2007_F123, 2'd0, 1, "R10");

    // Legacy layout.
    @(negedge clk); legacy_en = 1;
    cfg_write(0, 0, 0, 32'hA000_0041);                     // valid, 256K
    cfg_write(0, 0, 1, 32'h1000_0005);                     // ks=0 kp=1 pp=1
    lookup(32'h1003_0004, 2'd0, 0, "R7");                  // key0 pp1: RW X
    lookup(32'h1003_0004, 2'd0, 1, "R7");                  // key1 pp1: R X
    cfg_write(0, 0, 1, 32'h1000_0004);                     // pp=0
    lookup(32'h1003_0004, 2'd1, 1, "R7");                  // key1 pp0: none
    lookup(32'h1003_0004, 2'd1, 0, "R7");                  // key0 pp0: RW
    cfg_write(0, 0, 1, 32'h1000_000B);                     // ks=1 pp=3
    lookup(32'h1000_0000, 2'd0, 0, "R7");                  // key1 pp3: R
    cfg_write(0, 0, 1, 32'h1000_0006);                     // kp=1 pp=2
    lookup(32'h1000_0000, 2'd0, 1, "R7");                  // key1 pp2: RW
    cfg_write(0, 0, 0, 32'hA000_0001);                     // valid bit clear
    lookup(32'h1000_0000, 2'd0, 0, "R7");
    lookup(32'h1004_0000, 2'd0, 0, "R7");

    repeat (4) @(negedge clk);
    check(q.size() == 0 && nreq == nrsp, "R8",
          $sformatf("responses actual %0d expected %0d", nrsp, nreq));
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule